// File: doc/BRIEF.md
# Configurable Three-Valued Logic Unit

This unit applies a trit-parallel operation to two words of 27 balanced-ternary digits and registers the result. Four of its operations (conjunction, disjunction, negation and implication) follow a truth-table family that is picked at run time from five three-valued logics: Kleene, Łukasiewicz, Heyting, the paraconsistent RM3 and Bochvar. A mode trit names the logic. A sub-mode trit refines the choice, but only when the mode trit is N.

Three more operations do not depend on the mode: consensus, anti-consensus and a per-digit three-way compare. Every digit position is computed on its own. There is no carry between positions, and the registered word appears one clock after the inputs are presented. The registers that hold the mode and any flag generation belong to the surrounding datapath.

Top module: `tvl_unit`

## Requirements
- R1: Each trit is carried as 2 bits at bits [2i+1:2i] for trit i, with Z = 00, P = 01 and N = 11. An input code of 10 is read as Z, and the result never contains code 10.
- R2: The 3-bit operation select has this encoding: 0 AND, 1 OR, 2 NOT (of operand a), 3 IMPLICATION (a implies b), 4 consensus, 5 anti-consensus, 6 compare. Select value 7 yields an all-Z word.
- R3: The mode trit selects the logic as follows: Z selects Kleene and P selects Bochvar. When the mode is N, the sub-mode picks the logic: N selects Heyting, Z selects Łukasiewicz and P selects RM3. The sub-mode has no effect unless the mode is N, and a mode code of 10 acts as Z.
- R4: In all logics other than Bochvar, AND returns the lower of the two trits and OR returns the higher, with the order N < Z < P.
- R5: Under Bochvar, any Z input to AND, OR or IMPLICATION gives a Z output. With inputs drawn only from N and P, Bochvar gives the Boolean result.
- R6: NOT is plain negation (N↔P, Z→Z) in every logic except Heyting. Under Heyting, N maps to P, and both Z and P map to N.
- R7: IMPLICATION follows a distinct table in each logic. Kleene gives max(−a, b). Łukasiewicz gives min(P, −a+b+1). Heyting gives P when a ≤ b and gives b otherwise. RM3 gives P when a = N or b = P, gives Z for (Z,Z), and gives N otherwise. Bochvar gives Z when either input is Z and otherwise follows Kleene.
- R8: Consensus returns a where a equals b, and returns Z elsewhere, in every mode.
- R9: Anti-consensus returns Z where a equals b. Elsewhere it returns the third trit, the one absent from the pair. This holds in every mode.
- R10: Compare returns N, Z or P in each position as a[i] is below, equal to or above b[i], in every mode.
- R11: The result is registered. It reflects the inputs one clock later, reset clears it to all Z, and positions do not interact.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| opd_a | input | 54 | Operand a, 27 trits |
| opd_b | input | 54 | Operand b, 27 trits |
| op_sel | input | 3 | Operation select |
| logic_mode | input | 2 | Mode trit |
| logic_sub | input | 2 | Sub-mode trit, used only when the mode is N |
| result | output | 54 | Registered result, 27 trits |

## Verification
The assertions that compare the result with an operand assume that the operand uses only canonical trit codes, so the consensus check is gated on a canonical operand. The assertions that check for an all-Z result rely on code 10 decoding to Z, which keeps them valid for any input. Most bench vectors are built only from the three legal codes. Code 10 is applied on purpose in one directed task, and the consensus-agreement check is not expected to fire there. Each vector is held for a full clock, so every check that looks one cycle ahead sees stable inputs.

// File: rtl/tvl_pkg.sv
package tvl_pkg;

    typedef logic signed [2:0] tval_t;

    typedef enum logic [2:0] {
        OP_AND   = 3'd0,
        OP_OR    = 3'd1,
        OP_NOT   = 3'd2,
        OP_IMPL  = 3'd3,
        OP_CONS  = 3'd4,
        OP_ACONS = 3'd5,
        OP_CMP   = 3'd6,
        OP_NONE  = 3'd7
    } op_e;

    typedef enum logic [2:0] {
        LG_KLEENE  = 3'd0,
        LG_LUKA    = 3'd1,
        LG_HEYTING = 3'd2,
        LG_RM3     = 3'd3,
        LG_BOCHVAR = 3'd4
    } logic_e;

    localparam logic [1:0] CODE_Z = 2'b00;
    localparam logic [1:0] CODE_P = 2'b01;
    localparam logic [1:0] CODE_N = 2'b11;

    function automatic tval_t trit_dec(input logic [1:0] code);
        case (code)
            CODE_P:  trit_dec = 3'sd1;
            CODE_N:  trit_dec = -3'sd1;
            default: trit_dec = 3'sd0;
        endcase
    endfunction

    function automatic logic [1:0] trit_enc(input tval_t v);
        if (v > 3'sd0)      trit_enc = CODE_P;
        else if (v < 3'sd0) trit_enc = CODE_N;
        else                trit_enc = CODE_Z;
    endfunction

endpackage

// File: rtl/tvl_mode_decode.sv
module tvl_mode_decode
    import tvl_pkg::*;
(
    input  logic [1:0] mode_code,
    input  logic [1:0] sub_code,
    output logic_e     lg
);
    tval_t mode_v;
    tval_t sub_v;

    always_comb begin
        mode_v = trit_dec(mode_code);
        sub_v  = trit_dec(sub_code);
        if (mode_v > 3'sd0) begin
            lg = LG_BOCHVAR;
        end else if (mode_v == 3'sd0) begin
            lg = LG_KLEENE;
        end else if (sub_v < 3'sd0) begin
            lg = LG_HEYTING;
        end else if (sub_v == 3'sd0) begin
            lg = LG_LUKA;
        end else begin
            lg = LG_RM3;
        end
    end
endmodule

// File: rtl/tvl_trit_cell.sv
module tvl_trit_cell
    import tvl_pkg::*;
(
    input  logic [1:0] a_code,
    input  logic [1:0] b_code,
    input  op_e        op,
    input  logic_e     lg,
    output logic [1:0] y_code
);
    tval_t a, b, lo, hi, neg, imp, luk, r;
    logic  any_z;

    always_comb begin
        a     = trit_dec(a_code);
        b     = trit_dec(b_code);
        any_z = (a == 3'sd0) || (b == 3'sd0);
        lo    = (a < b) ? a : b;
        hi    = (a > b) ? a : b;

        if (lg == LG_HEYTING) neg = (a < 3'sd0) ? 3'sd1 : -3'sd1;
        else                  neg = -a;

        luk = -a + b + 3'sd1;
        case (lg)
            LG_LUKA:    imp = (luk > 3'sd1) ? 3'sd1 : luk;
            LG_HEYTING: imp = (a <= b) ? 3'sd1 : b;
            LG_RM3: begin
                if (a < 3'sd0 || b > 3'sd0)        imp = 3'sd1;
                else if (a == 3'sd0 && b == 3'sd0) imp = 3'sd0;
                else                                imp = -3'sd1;
            end
            LG_BOCHVAR: imp = any_z ? 3'sd0 : (((-a) > b) ? -a : b);
            default:    imp = ((-a) > b) ? -a : b;
        endcase

        case (op)
            OP_AND:   r = (lg == LG_BOCHVAR && any_z) ? 3'sd0 : lo;
            OP_OR:    r = (lg == LG_BOCHVAR && any_z) ? 3'sd0 : hi;
            OP_NOT:   r = neg;
            OP_IMPL:  r = imp;
            OP_CONS:  r = (a == b) ? a : 3'sd0;
            OP_ACONS: r = (a == b) ? 3'sd0 : -(a + b);
            OP_CMP:   r = (a > b) ? 3'sd1 : ((a < b) ? -3'sd1 : 3'sd0);
            default:  r = 3'sd0;
        endcase
        y_code = trit_enc(r);
    end
endmodule

// File: rtl/tvl_unit.sv
module tvl_unit
    import tvl_pkg::*;
#(
    parameter int NUM_TRITS = 27,
    localparam int WORD_W = 2 * NUM_TRITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] opd_a,
    input  logic [WORD_W-1:0] opd_b,
    input  logic [2:0]        op_sel,
    input  logic [1:0]        logic_mode,
    input  logic [1:0]        logic_sub,
    output logic [WORD_W-1:0] result
);
    typedef struct packed {
        logic [WORD_W-1:0] word;
    } state_t;

    state_t            st_d, st_q;
    logic_e            lg_sel;
    op_e               op_cur;
    logic [WORD_W-1:0] cell_y;

    assign op_cur = op_e'(op_sel);

    tvl_mode_decode u_mode (
        .mode_code (logic_mode),
        .sub_code  (logic_sub),
        .lg        (lg_sel)
    );

    for (genvar i = 0; i < NUM_TRITS; i++) begin : g_trit
        tvl_trit_cell u_cell (
            .a_code (opd_a[2*i +: 2]),
            .b_code (opd_b[2*i +: 2]),
            .op     (op_cur),
            .lg     (lg_sel),
            .y_code (cell_y[2*i +: 2])
        );
    end

    always_comb begin
        st_d      = st_q;
        st_d.word = cell_y;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign result = st_q.word;
endmodule

// File: rtl/tvl_unit_chk.sv
module tvl_unit_chk #(
    parameter int NUM_TRITS = 27,
    localparam int WORD_W = 2 * NUM_TRITS
) (
    input logic              clk,
    input logic              rst_n,
    input logic [WORD_W-1:0] opd_a,
    input logic [WORD_W-1:0] opd_b,
    input logic [2:0]        op_sel,
    input logic [1:0]        logic_mode,
    input logic [1:0]        logic_sub,
    input logic [WORD_W-1:0] result
);
    function automatic logic canon(input logic [WORD_W-1:0] w);
        canon = 1'b1;
        for (int i = 0; i < NUM_TRITS; i++)
            if (w[2*i +: 2] == 2'b10) canon = 1'b0;
    endfunction

    logic unused_sub;
    assign unused_sub = ^logic_sub;

    assert_result_canonical_R1: assert property (@(posedge clk) disable iff (!rst_n)
        canon(result));

    assert_spare_op_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 3'd7) |=> (result == '0));

    assert_bochvar_infect_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (logic_mode == 2'b01 && (op_sel == 3'd0 || op_sel == 3'd1 || op_sel == 3'd3)
         && opd_a == '0) |=> (result == '0));

    assert_cons_agree_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 3'd4 && opd_a == opd_b && canon(opd_a)) |=> (result == $past(opd_a)));

    assert_acons_equal_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 3'd5 && opd_a == opd_b) |=> (result == '0));

    assert_cmp_equal_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 3'd6 && opd_a == opd_b) |=> (result == '0));
endmodule

bind tvl_unit tvl_unit_chk #(.NUM_TRITS(NUM_TRITS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .opd_a      (opd_a),
    .opd_b      (opd_b),
    .op_sel     (op_sel),
    .logic_mode (logic_mode),
    .logic_sub  (logic_sub),
    .result     (result)
);

// File: tb/tvl_unit_test.sv
module tvl_unit_test;
    localparam int CLK_PERIOD = 10;
    localparam int NT = 27;
    localparam int W  = 2 * NT;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] opd_a = '0, opd_b = '0;
    logic [2:0]   op_sel = 3'd0;
    logic [1:0]   logic_mode = 2'b00, logic_sub = 2'b00;
    logic [W-1:0] result;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tvl_unit uut (
        .clk(clk), .rst_n(rst_n), .opd_a(opd_a), .opd_b(opd_b),
        .op_sel(op_sel), .logic_mode(logic_mode), .logic_sub(logic_sub),
        .result(result)
    );

    // logic index: 0 Kleene, 1 Lukasiewicz, 2 Heyting, 3 RM3, 4 Bochvar
    function automatic int tv(input logic [1:0] c);
        if (c == 2'b01) return 1;
        if (c == 2'b11) return -1;
        return 0;
    endfunction

    function automatic logic [1:0] ch2code(input byte c);
        if (c == "P") return 2'b01;
        if (c == "N") return 2'b11;
        return 2'b00;
    endfunction

    // tables indexed (a+1)*3+(b+1), rows a = N,Z,P, columns b = N,Z,P
    function automatic logic [1:0] exp_trit(input int op, input int lg, input int a, input int b);
        string s;
        int idx = (a + 1) * 3 + (b + 1);
        case (op)
            0: s = (lg == 4) ? "NZNZZZNZP" : "NNNNZZNZP";
            1: s = (lg == 4) ? "NZPZZZPZP" : "NZPZZPPPP";
            2: begin
                s = (lg == 2) ? "PNN" : "PZN";
                idx = a + 1;
            end
            3: case (lg)
                0: s = "PPPZZPNZP";
                1: s = "PPPZPPNZP";
                2: s = "PPPNPPNZP";
                3: s = "PPPNZPNNP";
                default: s = "PZPZZZNZP";
            endcase
            4: s = "NZZZZZZZP";
            5: s = "ZPZPZNZNZ";
            6: s = "ZNNPZNPPZ";
            default: return 2'b00;
        endcase
        return ch2code(s[idx]);
    endfunction

    function automatic logic [W-1:0] exp_word(input logic [W-1:0] a, input logic [W-1:0] b,
                                              input int op, input int lg);
        logic [W-1:0] w;
        for (int i = 0; i < NT; i++)
            w[2*i +: 2] = exp_trit(op, lg, tv(a[2*i +: 2]), tv(b[2*i +: 2]));
        return w;
    endfunction

    function automatic string tag_of(input int op, input int lg);
        case (op)
            0, 1: return (lg == 4) ? "R5" : "R4";
            2: return "R6";
            3: return (lg == 4) ? "R5" : "R7";
            4: return "R8";
            5: return "R9";
            6: return "R10";
            default: return "R2";
        endcase
    endfunction

    task automatic set_logic(input int lg);
        case (lg)
            0: begin logic_mode = 2'b00; logic_sub = 2'b00; end
            1: begin logic_mode = 2'b11; logic_sub = 2'b00; end
            2: begin logic_mode = 2'b11; logic_sub = 2'b11; end
            3: begin logic_mode = 2'b11; logic_sub = 2'b01; end
            default: begin logic_mode = 2'b01; logic_sub = 2'b00; end
        endcase
    endtask

    task automatic check(input string tag, input logic [W-1:0] exp);
        n_checks++;
        if (result !== exp) begin
            n_fails++;
            $display("FAIL %s: result=%h expected=%h", tag, result, exp);
        end
    endtask

    // drive on falling edge, register on rising edge, sample next falling edge (R11)
    task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b, input logic [2:0] op);
        @(negedge clk);
        opd_a  = a;
        opd_b  = b;
        op_sel = op;
        @(negedge clk);
    endtask

    task automatic pair_words(output logic [W-1:0] a, output logic [W-1:0] b);
        for (int i = 0; i < NT; i++) begin
            int p = i % 9;
            int av = p / 3 - 1;
            int bv = p % 3 - 1;
            a[2*i +: 2] = (av > 0) ? 2'b01 : ((av < 0) ? 2'b11 : 2'b00);
            b[2*i +: 2] = (bv > 0) ? 2'b01 : ((bv < 0) ? 2'b11 : 2'b00);
        end
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        opd_a = {NT{2'b01}};
        opd_b = {NT{2'b11}};
        op_sel = 3'd1;
        repeat (3) @(negedge clk);
        check("R11 reset", '0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_exhaustive;
        logic [W-1:0] a, b;
        pair_words(a, b);
        for (int op = 0; op < 7; op++)
            for (int lg = 0; lg < 5; lg++) begin
                set_logic(lg);
                apply(a, b, 3'(op));
                check(tag_of(op, lg), exp_word(a, b, op, lg));
            end
    endtask

    task automatic t_submode_ignored;
        logic [W-1:0] a, b;
        pair_words(a, b);
        for (int s = 0; s < 3; s++) begin
            logic [1:0] sc = (s == 0) ? 2'b11 : ((s == 1) ? 2'b01 : 2'b10);
            logic_mode = 2'b00; logic_sub = sc;
            apply(a, b, 3'd3);
            check("R3 Kleene sub ignored", exp_word(a, b, 3, 0));
            logic_mode = 2'b01;
            apply(a, b, 3'd3);
            check("R3 Bochvar sub ignored", exp_word(a, b, 3, 4));
        end
        logic_mode = 2'b10; logic_sub = 2'b11;
        apply(a, b, 3'd3);
        check("R3 mode code 10 as Z", exp_word(a, b, 3, 0));
        logic_mode = 2'b11; logic_sub = 2'b10;
        apply(a, b, 3'd3);
        check("R3 sub code 10 as Z", exp_word(a, b, 3, 1));
    endtask

    task automatic t_spare_op;
        set_logic(2);
        apply({NT{2'b01}}, {NT{2'b11}}, 3'd7);
        check("R2 spare select", '0);
    endtask

    task automatic t_code10;
        logic [W-1:0] a, b, a_z;
        pair_words(a, b);
        a_z = a;
        for (int i = 0; i < NT; i++)
            if (a[2*i +: 2] == 2'b00) a[2*i +: 2] = 2'b10;
        set_logic(0);
        apply(a, b, 3'd6);
        check("R1 code 10 compare", exp_word(a_z, b, 6, 0));
        apply(a, b, 3'd2);
        check("R1 code 10 negate", exp_word(a_z, b, 2, 0));
    endtask

    task automatic t_bool_only;
        logic [W-1:0] a, b;
        for (int i = 0; i < NT; i++) begin
            a[2*i +: 2] = (i % 2 == 0) ? 2'b01 : 2'b11;
            b[2*i +: 2] = (i % 4 < 2) ? 2'b01 : 2'b11;
        end
        for (int op = 0; op < 4; op++) begin
            set_logic(4);
            apply(a, b, 3'(op));
            check("R5 Boolean inputs", exp_word(a, b, op, 0));
        end
    endtask

    task automatic t_random;
        for (int k = 0; k < 300; k++) begin
            logic [W-1:0] a, b;
            int op = $urandom % 7;
            int lg = $urandom % 5;
            for (int i = 0; i < NT; i++) begin
                int ra = $urandom % 3;
                int rb = $urandom % 3;
                a[2*i +: 2] = (ra == 0) ? 2'b00 : ((ra == 1) ? 2'b01 : 2'b11);
                b[2*i +: 2] = (rb == 0) ? 2'b00 : ((rb == 1) ? 2'b01 : 2'b11);
            end
            set_logic(lg);
            apply(a, b, 3'(op));
            check({tag_of(op, lg), " R11 random"}, exp_word(a, b, op, lg));
        end
    endtask

    task automatic summary;
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        t_reset;
        t_exhaustive;
        t_submode_ignored;
        t_spare_op;
        t_code10;
        t_bool_only;
        t_random;
        summary;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: run did not complete");
        summary;
    end
endmodule